// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is the two-level logic core of a small programmable logic device. A vector of up to twenty signals (fixed inputs, a pin that serves as clock or input, and the eight cell feedbacks, gathered by the caller) is fed to a plane of programmable AND terms. Each AND term sees both the true and the inverted form of every signal. A static fuse vector chooses which of those literals each term uses, and whether the term is switched off.

The term outputs are then ORed into eight sums. The distribution is uneven: the first four sums each gather twelve terms and the last four gather eight. Beyond the eighty sum terms there are ten more dedicated terms. Eight of them drive one output-enable line per cell, and the last two drive the shared asynchronous preset and reset of the registers. The array holds no state. Its outputs follow the signal and fuse inputs combinationally, and they feed the output cells that sit outside this block.

Top module: `pla_array`

## Requirements
- R1: Term t is configured by fuse bits [t*41 +: 41]. Within that row, bit 2i connects the true literal of signal i and bit 2i+1 connects its inverted literal. An enabled term is 1 exactly when every connected literal is 1.
- R2: An enabled term with no literal connected evaluates to 1.
- R3: An enabled term that connects both literals of any one signal evaluates to 0, whatever the signal values.
- R4: Bit 40 of a term's row disables the term and forces it to 0, whatever its literals.
- R5: Sum output k (k = 0..3) owns terms 12k to 12k+11. Sum output k (k = 4..7) owns terms 48+8(k-4) to 55+8(k-4).
- R6: Each sum output is the OR of its own terms and of no other term. It is 0 when all of its terms are 0.
- R7: Output-enable line k is driven by term 80+k alone.
- R8: The preset line is driven by term 88 alone, and the reset line by term 89 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sig_i | input | 20 | Input and feedback signals that feed the array |
| fuse_i | input | 3690 | Static fuse rows, 41 bits per term, 90 terms |
| sum_o | output | 8 | OR of each output's product terms |
| oe_o | output | 8 | Dedicated output-enable product terms |
| preset_o | output | 1 | Shared asynchronous preset product term |
| reset_o | output | 1 | Shared asynchronous reset product term |

## Verification
The bench builds the array with its default parameters: twenty signals, eight outputs, four wide outputs of twelve terms and four narrow outputs of eight terms. With these values the boundary between the wide and narrow term groups (terms 47 and 48) can be reached, as can the edge between the sum region and the dedicated control terms (terms 79 and 80). Walking a single live term across all ninety positions shows that each term reaches exactly one output. Sparse random fuse rows then mix literals, contradictions and disabled terms.

// File: rtl/pla_pkg.sv
package pla_pkg;

   // first term index of output k when wide outputs come first
   function automatic int slice_base(int k, int wide_outs, int wide_n, int narrow_n);
      if (k <= wide_outs) return k * wide_n;
      return wide_outs * wide_n + (k - wide_outs) * narrow_n;
   endfunction

   function automatic int slice_size(int k, int wide_outs, int wide_n, int narrow_n);
      return (k < wide_outs) ? wide_n : narrow_n;
   endfunction

endpackage

// File: rtl/pla_term.sv
module pla_term #(
   parameter int N_IN = 20
) (
   input  logic [N_IN-1:0]   sig_i,
   input  logic [2*N_IN:0]   row_i,
   output logic              prod_o
);
   localparam int ROW_W = 2 * N_IN + 1;

   logic [N_IN-1:0] use_t;
   logic [N_IN-1:0] use_c;
   logic [N_IN-1:0] lit_ok;
   logic            off;

   assign off = row_i[ROW_W-1];

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign use_t[i]  = row_i[2*i];
      assign use_c[i]  = row_i[2*i+1];
      assign lit_ok[i] = (~use_t[i] | sig_i[i]) & (~use_c[i] | ~sig_i[i]);
   end

   assign prod_o = ~off & (&lit_ok);

   always_comb begin
      if (!off && (|(use_t & use_c))) begin
         // R3
         contra_term_chk: assert (prod_o == 1'b0)
            else $error("contradictory term evaluated high");
      end
      if (!off && !(|use_t) && !(|use_c)) begin
         // R2
         empty_term_chk: assert (prod_o == 1'b1)
            else $error("empty term evaluated low");
      end
   end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
   parameter int N_IN    = 20,
   parameter int N_TERMS = 90
) (
   input  logic [N_IN-1:0]                  sig_i,
   input  logic [N_TERMS*(2*N_IN+1)-1:0]    fuse_i,
   output logic [N_TERMS-1:0]               term_o
);
   localparam int ROW_W = 2 * N_IN + 1;

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      pla_term #(.N_IN(N_IN)) u_term (
         .sig_i  (sig_i),
         .row_i  (fuse_i[t*ROW_W +: ROW_W]),
         .prod_o (term_o[t])
      );
   end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_OUT     = 8,
   parameter int WIDE_OUTS = 4,
   parameter int WIDE_N    = 12,
   parameter int NARROW_N  = 8,
   parameter int SUM_TERMS = 80
) (
   input  logic [SUM_TERMS-1:0] term_i,
   output logic [N_OUT-1:0]     sum_o
);
   for (genvar k = 0; k < N_OUT; k++) begin : g_sum
      localparam int BASE = pla_pkg::slice_base(k, WIDE_OUTS, WIDE_N, NARROW_N);
      if (k < WIDE_OUTS) begin : g_wide
         assign sum_o[k] = |term_i[BASE +: WIDE_N];
      end else begin : g_narrow
         assign sum_o[k] = |term_i[BASE +: NARROW_N];
      end
   end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
   parameter  int N_IN      = 20,
   parameter  int N_OUT     = 8,
   parameter  int WIDE_OUTS = 4,
   parameter  int WIDE_N    = 12,
   parameter  int NARROW_N  = 8,
   localparam int ROW_W     = 2 * N_IN + 1,
   localparam int SUM_TERMS = WIDE_OUTS * WIDE_N + (N_OUT - WIDE_OUTS) * NARROW_N,
   localparam int N_TERMS   = SUM_TERMS + N_OUT + 2,
   localparam int FUSE_W    = N_TERMS * ROW_W
) (
   input  logic [N_IN-1:0]   sig_i,
   input  logic [FUSE_W-1:0] fuse_i,
   output logic [N_OUT-1:0]  sum_o,
   output logic [N_OUT-1:0]  oe_o,
   output logic              preset_o,
   output logic              reset_o
);
   localparam int OE_BASE    = SUM_TERMS;
   localparam int PRESET_IDX = SUM_TERMS + N_OUT;
   localparam int RESET_IDX  = PRESET_IDX + 1;

   if (N_IN < 1 || N_OUT < 1) begin : g_bad_size
      $error("pla_array: N_IN and N_OUT must be positive");
   end
   if (WIDE_OUTS < 0 || WIDE_OUTS > N_OUT) begin : g_bad_split
      $error("pla_array: WIDE_OUTS out of range");
   end
   if (WIDE_N < 1 || NARROW_N < 1) begin : g_bad_terms
      $error("pla_array: term counts must be positive");
   end

   logic [N_TERMS-1:0] term;

   pla_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
      .sig_i  (sig_i),
      .fuse_i (fuse_i),
      .term_o (term)
   );

   pla_or_plane #(
      .N_OUT(N_OUT), .WIDE_OUTS(WIDE_OUTS), .WIDE_N(WIDE_N),
      .NARROW_N(NARROW_N), .SUM_TERMS(SUM_TERMS)
   ) u_or (
      .term_i (term[SUM_TERMS-1:0]),
      .sum_o  (sum_o)
   );

   assign oe_o     = term[OE_BASE +: N_OUT];
   assign preset_o = term[PRESET_IDX];
   assign reset_o  = term[RESET_IDX];

   always_comb begin
      for (int t = 0; t < N_TERMS; t++) begin
         if (fuse_i[t*ROW_W + ROW_W - 1]) begin
            // R4
            off_term_chk: assert (term[t] == 1'b0)
               else $error("disabled term %0d is high", t);
         end
      end
   end

   always_comb begin
      int   b;
      int   n;
      logic all_off;
      for (int k = 0; k < N_OUT; k++) begin
         b = pla_pkg::slice_base(k, WIDE_OUTS, WIDE_N, NARROW_N);
         n = pla_pkg::slice_size(k, WIDE_OUTS, WIDE_N, NARROW_N);
         all_off = 1'b1;
         for (int j = 0; j < WIDE_N; j++) begin
            if (j < n && !fuse_i[(b + j)*ROW_W + ROW_W - 1]) all_off = 1'b0;
         end
         if (all_off) begin
            // R6
            idle_sum_chk: assert (sum_o[k] == 1'b0)
               else $error("sum %0d high with all terms disabled", k);
         end
      end
   end
endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;
   localparam int NI = 20;
   localparam int NO = 8;
   localparam int RW = 41;
   localparam int NT = 90;

   typedef struct {
      logic [NO-1:0] s;
      logic [NO-1:0] o;
      logic          p;
      logic          r;
      string         tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [NI-1:0]    sig;
   logic [NT*RW-1:0] fuse;
   logic [NO-1:0]    sum_o, oe_o;
   logic             preset_o, reset_o;

   pla_array u0 (
      .sig_i(sig), .fuse_i(fuse), .sum_o(sum_o), .oe_o(oe_o),
      .preset_o(preset_o), .reset_o(reset_o)
   );

   item_t q[$];
   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;
   bit done    = 0;

   function automatic logic eval_term(int t);
      logic v;
      v = 1'b1;
      if (fuse[t*RW + 2*NI]) return 1'b0;
      for (int i = 0; i < NI; i++) begin
         if (fuse[t*RW + 2*i]   && !sig[i]) v = 1'b0;
         if (fuse[t*RW + 2*i+1] &&  sig[i]) v = 1'b0;
      end
      return v;
   endfunction

   task automatic apply(string tag);
      item_t it;
      int base;
      base = 0;
      for (int k = 0; k < NO; k++) begin
         int cnt;
         cnt = (k < 4) ? 12 : 8;
         it.s[k] = 1'b0;
         for (int j = 0; j < cnt; j++) it.s[k] = it.s[k] | eval_term(base + j);
         base += cnt;
      end
      for (int k = 0; k < NO; k++) it.o[k] = eval_term(80 + k);
      it.p = eval_term(88);
      it.r = eval_term(89);
      it.tag = tag;
      q.push_back(it);
      @(posedge clk);
   endtask

   task automatic all_off();
      fuse = '0;
      for (int t = 0; t < NT; t++) fuse[t*RW + 2*NI] = 1'b1;
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t e;
         e = q.pop_front();
         vectors++;
         if ({sum_o, oe_o, preset_o, reset_o} !== {e.s, e.o, e.p, e.r}) begin
            errors++;
            $display("FAIL %s: got %h expected %h", e.tag,
                     {sum_o, oe_o, preset_o, reset_o}, {e.s, e.o, e.p, e.r});
         end
      end
   end

   initial begin
      sig = '0;
      all_off();
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(posedge clk);

      // R4: every term disabled, all lines low (start-up state)
      sig = '1;
      apply("R4 all disabled");
      // R2: every term enabled and empty, all lines high
      fuse = '0;
      apply("R2 empty terms");
      // R3: every term ties both literals of signal 0
      for (int t = 0; t < NT; t++) fuse[t*RW +: 2] = 2'b11;
      sig = 20'h00001;
      apply("R3 contradiction sig0=1");
      sig = 20'h00000;
      apply("R3 contradiction sig0=0");

      // R5 R6 R7 R8: one live empty term walked over every position
      for (int t = 0; t < NT; t++) begin
         all_off();
         fuse[t*RW + 2*NI] = 1'b0;
         sig = 20'h5a5a5;
         if (t < 80)      apply("R5 R6 term walk");
         else if (t < 88) apply("R7 enable term walk");
         else             apply("R8 preset/reset term");
      end

      // R1: single true literal on term 0, single inverted literal on term 48
      for (int i = 0; i < NI; i++) begin
         all_off();
         fuse[0*RW + 2*NI] = 1'b0;
         fuse[0*RW + 2*i] = 1'b1;
         fuse[48*RW + 2*NI] = 1'b0;
         fuse[48*RW + 2*i+1] = 1'b1;
         sig = 20'(1) << i;
         apply("R1 literal high");
         sig = ~(20'(1) << i);
         apply("R1 literal low");
      end

      // R1 R3 R4 R6: sparse random rows
      for (int n = 0; n < 300; n++) begin
         for (int b = 0; b < NT*RW; b++) fuse[b] = ($urandom % 14 == 0);
         for (int t = 0; t < NT; t++) fuse[t*RW + 2*NI] = ($urandom % 4 == 0);
         sig = 20'($urandom);
         apply("R1 R6 random rows");
      end

      @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule